// File: doc/BRIEF.md
# Nine-Bit Multidrop Address Filter

This block sits between a UART receiver running with nine-bit characters and the receive FIFO. On a shared multidrop line, a transmitter picks one station by sending a character whose ninth bit is set (a marked frame). That frame carries a station address in its low byte. The stations it names accept the following unmarked characters, and every other station throws them away. The filter keeps one bit of state, which records whether this station is currently selected. It uses that bit to decide, character by character, which received frames are passed on.

The filter changes state only on marked frames. A marked frame whose low byte equals the station's own address selects the station, and that frame is itself passed on. A marked frame with any other address deselects the station and is dropped. Unmarked frames never change the state; they pass only while the station is selected. The filter acts only when address detection and nine-bit mode are both switched on. Otherwise every character passes through untouched and the selected indicator stays low. Each result is registered, so the filtered character appears one clock after it is received.

Top module: `mdf_filter`

## Requirements
- R1: While reset is asserted and after it is released, `flt_valid` and `addressed` are 0 until a frame selects the station.
- R2: With filtering on (`addr_detect_en`=1 and `nine_bit_en`=1), a frame with bit 8 = 1 is an address frame and a frame with bit 8 = 0 is a data frame. A data frame never changes `addressed`, even when its low byte equals `own_addr`.
- R3: With filtering on, an address frame whose bits 7:0 equal `own_addr` sets `addressed` to 1. The frame is presented one cycle later on `flt_char` with all 9 bits unchanged and `flt_valid`=1. This also holds when the station is already selected.
- R4: With filtering on and `addressed`=1, each data frame is presented unchanged one cycle later with `flt_valid`=1.
- R5: With filtering on and `addressed`=0, data frames are discarded: `flt_valid` stays 0 and `addressed` stays 0.
- R6: With filtering on, an address frame whose bits 7:0 differ from `own_addr` clears `addressed` on the next edge and is itself discarded.
- R7: With `addr_detect_en`=0 or `nine_bit_en`=0, every received frame is presented one cycle later with all 9 bits unchanged, whatever its bit 8 and address.
- R8: `addressed` is 0 from the clock edge after filtering turns off. When filtering turns back on, the station starts unselected.
- R9: `flt_valid` is 1 only in the cycle after a cycle with `rx_valid`=1, and is 1 for exactly one cycle per forwarded frame.
- R10: Frames on consecutive cycles are each handled in turn. A selecting address frame takes effect for a data frame received in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received character is present on `rx_char` this cycle |
| rx_char | input | 9 | Received character; bit 8 is the address mark |
| own_addr | input | 8 | This station's address |
| addr_detect_en | input | 1 | Enables address filtering |
| nine_bit_en | input | 1 | Receiver is in nine-bit character mode |
| flt_valid | output | 1 | A forwarded character is present on `flt_char` |
| flt_char | output | 9 | Forwarded character, unchanged from input |
| addressed | output | 1 | Station is currently selected |

## Verification
Every result is due exactly one clock after its cause. A frame offered in one cycle shows up, or is missing, on `flt_valid`/`flt_char` after the next rising edge. A selecting or deselecting address frame, or a change of the enables, shows on `addressed` at that same edge. The bench drives inputs on the falling edge. It checks the outputs at the next falling edge, so each check looks at the state exactly one rising edge after the stimulus. A behavioural model, updated on the same rising edge, is compared against the outputs on every falling edge throughout directed and random traffic.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

  // Classification of one received character.
  typedef enum logic [1:0] {
    KIND_DATA      = 2'd0,
    KIND_ADDR_HIT  = 2'd1,
    KIND_ADDR_MISS = 2'd2
  } frame_kind_e;

endpackage

// File: rtl/mdf_classify.sv
module mdf_classify
  import mdf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W:0]   char_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output frame_kind_e       kind_o
);

  localparam int MARK_POS = ADDR_W;

  function automatic logic has_mark(input logic [ADDR_W:0] c);
    return c[MARK_POS];
  endfunction

  function automatic logic addr_hit(input logic [ADDR_W:0] c,
                                    input logic [ADDR_W-1:0] own);
    return (c[ADDR_W-1:0] == own);
  endfunction

  always_comb begin
    if (!has_mark(char_i)) begin
      kind_o = KIND_DATA;
    end else if (addr_hit(char_i, own_addr_i)) begin
      kind_o = KIND_ADDR_HIT;
    end else begin
      kind_o = KIND_ADDR_MISS;
    end
  end

endmodule

// File: rtl/mdf_addr_state.sv
module mdf_addr_state
  import mdf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_valid_i,
  input  logic        filter_on_i,
  input  frame_kind_e kind_i,
  output logic        addressed_o,
  output logic        forward_o
);

  logic sel_q;
  logic sel_d;

  // Forwarding decision for the frame present this cycle.
  always_comb begin
    if (!filter_on_i) begin
      forward_o = 1'b1;
    end else begin
      unique case (kind_i)
        KIND_ADDR_HIT:  forward_o = 1'b1;
        KIND_ADDR_MISS: forward_o = 1'b0;
        default:        forward_o = sel_q;
      endcase
    end
  end

  // Next selection state: only marked frames move it.
  always_comb begin
    sel_d = sel_q;
    if (!filter_on_i) begin
      sel_d = 1'b0;
    end else if (frame_valid_i) begin
      if (kind_i == KIND_ADDR_HIT) begin
        sel_d = 1'b1;
      end else if (kind_i == KIND_ADDR_MISS) begin
        sel_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign addressed_o = sel_q;

endmodule

// File: rtl/mdf_out_stage.sv
module mdf_out_stage #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] char_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      char_o  <= '0;
    end else begin
      valid_o <= take_i;
      if (take_i) begin
        char_o <= char_i;
      end
    end
  end

endmodule

// File: rtl/mdf_filter.sv
module mdf_filter
  import mdf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [ADDR_W:0]   rx_char,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_detect_en,
  input  logic              nine_bit_en,
  output logic              flt_valid,
  output logic [ADDR_W:0]   flt_char,
  output logic              addressed
);

  localparam int CHAR_W = ADDR_W + 1;

  frame_kind_e kind;
  logic        filter_on;
  logic        forward;
  logic        take;

  // Named events for the checker.
  logic        evt_addr_hit;
  logic        evt_addr_miss;
  logic        evt_data_drop;

  assign filter_on = addr_detect_en & nine_bit_en;

  mdf_classify #(.ADDR_W(ADDR_W)) u_classify (
    .char_i     (rx_char),
    .own_addr_i (own_addr),
    .kind_o     (kind)
  );

  mdf_addr_state u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_valid_i (rx_valid),
    .filter_on_i   (filter_on),
    .kind_i        (kind),
    .addressed_o   (addressed),
    .forward_o     (forward)
  );

  assign take = rx_valid & forward;

  assign evt_addr_hit  = rx_valid & filter_on & (kind == KIND_ADDR_HIT);
  assign evt_addr_miss = rx_valid & filter_on & (kind == KIND_ADDR_MISS);
  assign evt_data_drop = rx_valid & filter_on & (kind == KIND_DATA) & ~forward;

  mdf_out_stage #(.CHAR_W(CHAR_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .char_i  (rx_char),
    .valid_o (flt_valid),
    .char_o  (flt_char)
  );

endmodule

// File: rtl/mdf_filter_chk.sv
module mdf_filter_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [ADDR_W:0]   rx_char,
  input logic [ADDR_W-1:0] own_addr,
  input logic              addr_detect_en,
  input logic              nine_bit_en,
  input logic              flt_valid,
  input logic [ADDR_W:0]   flt_char,
  input logic              addressed,
  input logic              evt_addr_hit,
  input logic              evt_addr_miss,
  input logic              evt_data_drop
);

  logic on;
  assign on = addr_detect_en && nine_bit_en;

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!flt_valid && !addressed);
    end
  end

  // R2
  event_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_addr_hit, evt_addr_miss, evt_data_drop}));

  // R2
  data_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && on && !rx_char[ADDR_W]) |=> (addressed == $past(addressed)));

  // R3
  hit_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && on && rx_char[ADDR_W] && rx_char[ADDR_W-1:0] == own_addr)
      |=> (addressed && flt_valid && flt_char == $past(rx_char)));

  // R4
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && on && !rx_char[ADDR_W] && addressed)
      |=> (flt_valid && flt_char == $past(rx_char)));

  // R5
  data_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && on && !rx_char[ADDR_W] && !addressed) |=> (!flt_valid && !addressed));

  // R6
  miss_deselects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && on && rx_char[ADDR_W] && rx_char[ADDR_W-1:0] != own_addr)
      |=> (!addressed && !flt_valid));

  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !on) |=> (flt_valid && flt_char == $past(rx_char)));

  // R8
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !addressed);

  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !flt_valid);

endmodule

bind mdf_filter mdf_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_valid       (rx_valid),
  .rx_char        (rx_char),
  .own_addr       (own_addr),
  .addr_detect_en (addr_detect_en),
  .nine_bit_en    (nine_bit_en),
  .flt_valid      (flt_valid),
  .flt_char       (flt_char),
  .addressed      (addressed),
  .evt_addr_hit   (evt_addr_hit),
  .evt_addr_miss  (evt_addr_miss),
  .evt_data_drop  (evt_data_drop)
);

// File: tb/tb_mdf_filter.sv
module tb_mdf_filter;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [AW:0]   rx_char = '0;
  logic [AW-1:0] own_addr = 8'h5A;
  logic          addr_detect_en = 1'b0;
  logic          nine_bit_en = 1'b0;
  logic          flt_valid;
  logic [AW:0]   flt_char;
  logic          addressed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model_live = 1'b0;

  // Reference model state
  bit          m_valid;
  logic [AW:0] m_char;
  bit          m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdf_filter #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .own_addr(own_addr), .addr_detect_en(addr_detect_en), .nine_bit_en(nine_bit_en),
    .flt_valid(flt_valid), .flt_char(flt_char), .addressed(addressed)
  );

  // Behavioural model: one-cycle latency, selection moved only by marked frames.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_sel   <= 1'b0;
      m_char  <= '0;
    end else if (!(addr_detect_en && nine_bit_en)) begin
      m_sel   <= 1'b0;
      m_valid <= rx_valid;
      if (rx_valid) m_char <= rx_char;
    end else begin
      m_valid <= 1'b0;
      if (rx_valid && rx_char[AW]) begin
        m_sel <= (rx_char[AW-1:0] == own_addr);
        if (rx_char[AW-1:0] == own_addr) begin
          m_valid <= 1'b1;
          m_char  <= rx_char;
        end
      end else if (rx_valid && m_sel) begin
        m_valid <= 1'b1;
        m_char  <= rx_char;
      end
    end
  end

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (model_live && rst_n) begin
      chk("R9 flt_valid vs model", flt_valid, m_valid);
      chk("R8 addressed vs model", addressed, m_sel);
      if (m_valid) chk("R4 flt_char vs model", flt_char, m_char);
    end
  end

  task automatic send(input logic [AW:0] c);
    rx_valid = 1'b1;
    rx_char  = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    idle(3);
    chk("R1 reset flt_valid", flt_valid, 0);
    chk("R1 reset addressed", addressed, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after release addressed", addressed, 0);
    model_live = 1'b1;

    addr_detect_en = 1'b1;
    nine_bit_en    = 1'b1;
    idle(1);

    send(9'h033);
    chk("R5 unaddressed data dropped", flt_valid, 0);
    chk("R5 stays unaddressed", addressed, 0);

    send(9'h15A);
    chk("R3 hit forwarded", flt_valid, 1);
    chk("R3 hit char", flt_char, 9'h15A);
    chk("R3 hit selects", addressed, 1);

    send(9'h0C4);
    chk("R4 data forwarded", flt_valid, 1);
    chk("R4 data char", flt_char, 9'h0C4);

    send(9'h15A);
    chk("R3 repeat hit keeps selection", addressed, 1);
    chk("R3 repeat hit forwarded", flt_valid, 1);

    send(9'h05A);
    chk("R2 unmarked own value is data", flt_char, 9'h05A);
    chk("R2 data keeps selection", addressed, 1);

    send(9'h1A5);
    chk("R6 miss dropped", flt_valid, 0);
    chk("R6 miss deselects", addressed, 0);

    send(9'h05A);
    chk("R2 unmarked own value does not select", addressed, 0);
    chk("R5 dropped after miss", flt_valid, 0);

    send(9'h15A);
    chk("R10 first of pair", flt_valid, 1);
    send(9'h011);
    chk("R10 data right after hit", flt_valid, 1);
    chk("R10 data char", flt_char, 9'h011);
    send(9'h1A5);
    send(9'h022);
    chk("R10 data right after miss dropped", flt_valid, 0);

    idle(1);
    chk("R9 no output without input", flt_valid, 0);

    send(9'h15A);
    chk("R8 selected before turn-off", addressed, 1);
    addr_detect_en = 1'b0;
    idle(1);
    chk("R8 cleared one edge after turn-off", addressed, 0);

    send(9'h1A5);
    chk("R7 bypass marked miss forwarded", flt_valid, 1);
    chk("R7 bypass char unchanged", flt_char, 9'h1A5);
    send(9'h033);
    chk("R7 bypass data char", flt_char, 9'h033);

    addr_detect_en = 1'b1;
    nine_bit_en    = 1'b0;
    send(9'h1A5);
    chk("R7 eight-bit mode forwards", flt_char, 9'h1A5);
    chk("R7 eight-bit mode addressed low", addressed, 0);

    nine_bit_en = 1'b1;
    send(9'h044);
    chk("R8 re-enabled starts unselected", flt_valid, 0);

    // Random traffic, compared every cycle against the model.
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 8;
      rx_valid = ($urandom % 3) != 0;
      if (r < 2)      rx_char = {1'b1, own_addr};
      else if (r < 4) rx_char = {1'b1, 8'($urandom)};
      else            rx_char = {1'b0, 8'($urandom)};
      if (($urandom % 64) == 0) addr_detect_en = ~addr_detect_en;
      if (($urandom % 64) == 0) nine_bit_en = ~nine_bit_en;
      if (($urandom % 200) == 0) own_addr = 8'($urandom);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    idle(2);

    done = 1'b1;
    summary();
  end

endmodule